// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Programmable Overlap

This block compares the rising edges of a reference clock and a divided feedback clock. It raises an "advance" output on each reference rise and a "retard" output on each feedback rise. When both outputs are high, a reset path clears them both, so the difference between the two pulse widths gives the phase error. Both inputs are sampled on a fast tick clock, and every time is counted in ticks of that clock.

The reset path is a down-counter loaded from a small programmable delay. Both outputs stay high together for that many ticks before they are cleared. This forced overlap appears on every comparison, including when the two edges are exactly aligned. A downstream charge pump therefore always receives a pulse of measurable width, and there is no dead zone around zero phase error. While the clear is pending, the detector does not react to new rising edges.

Top module: `pfd_overlap`

## Requirements
- R1: While `rst_ni` is low, `up_o` and `dn_o` are 0. After release they stay 0 until a rising edge is seen on an input. Both inputs are treated as low before the first sample.
- R2: A 0-to-1 change of `ref_i` between two tick samples sets `up_o` at the next `clk_i` rising edge. A 0-to-1 change of `fb_i` sets `dn_o` in the same way.
- R3: Once both outputs are high, they stay high together for exactly D ticks. They then fall on the same clock edge. D is the effective delay.
- R4: The effective delay D equals `dly_i`, except that a `dly_i` of 0 is taken as 1. The overlap is therefore never shorter than one tick.
- R5: When the reference leads by P ticks, `up_o` is high for P+D ticks and `dn_o` for D ticks. When the feedback leads by P ticks, the widths are swapped.
- R6: When both rising edges arrive in the same tick, both outputs are high for exactly D ticks, and the width difference is 0.
- R7: A rising edge on either input that arrives while the overlap clear is pending is ignored. An input that is still high when the clear ends does not set its output again. Rising edges after the clear are captured normally.
- R8: An input held high produces only one capture. An output that is low is set only by a rising edge of its own input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference clock level |
| fb_i | input | 1 | Divided feedback clock level |
| dly_i | input | DLY_W | Overlap length in ticks (0 is taken as 1) |
| up_o | output | 1 | Advance pulse, set by a reference rise |
| dn_o | output | 1 | Retard pulse, set by a feedback rise |

## Verification
The hardest case to reach from the ports is a new rising edge that arrives inside the overlap window. The case must also be followed by a fresh edge after the clear, to show that capture resumes. The stimulus produces an aligned pair with an 8-tick overlap. It then pulls the reference low and raises it again while the clear is pending, so the reference is still high when the clear ends. The feedback then rises again after the clear, followed by the reference. The total widths show that the edge inside the window was dropped and that the edge held across the release was not captured again. The pair after the clear is measured normally.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    parameter int unsigned DLY_W = 4;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_out_t;

    typedef struct packed {
        logic             active;
        logic [DLY_W-1:0] cnt;
    } pfd_timer_t;
endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    // A held level cannot report two rises in a row
    assert_single_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_overlap_timer.sv
module pfd_overlap_timer
    import pfd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

    pfd_timer_t st_d, st_q;
    logic [DLY_W-1:0] load_val;

    always_comb begin
        load_val = (dly_i == '0) ? ONE : dly_i;
        busy_o   = st_q.active;
        done_o   = st_q.active && (st_q.cnt == ONE);
        st_d     = st_q;
        if (arm_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = load_val;
        end else if (st_q.active) begin
            if (st_q.cnt == ONE) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assert_cnt_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.active |-> (st_q.cnt != '0));
    assert_ends_after_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !arm_i) |=> !st_q.active);
    assert_keeps_running_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && !done_o) |=> st_q.active);
endmodule

// File: rtl/pfd_overlap.sv
module pfd_overlap
    import pfd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             up_o,
    output logic             dn_o
);
    logic [1:0] lvl, rise;
    logic       busy, done, arm;
    pfd_out_t   out_d, out_q;

    assign lvl = {fb_i, ref_i};

    for (genvar g = 0; g < 2; g++) begin : g_det
        pfd_rise_det u_det (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .lvl_i  (lvl[g]),
            .rise_o (rise[g])
        );
    end

    always_comb begin
        out_d = out_q;
        if (busy) begin
            if (done) out_d = '0;
        end else begin
            out_d.up = out_q.up | rise[0];
            out_d.dn = out_q.dn | rise[1];
        end
        arm = !busy && out_d.up && out_d.dn;
    end

    pfd_overlap_timer u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm),
        .dly_i  (dly_i),
        .busy_o (busy),
        .done_o (done)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign up_o = out_q.up;
    assign dn_o = out_q.dn;

    assert_both_high_timed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_q.up && out_q.dn) |-> busy);
    assert_clear_together_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done |=> (!out_q.up && !out_q.dn));
    assert_ignore_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy && !done) |=> ($stable(out_q.up) && $stable(out_q.dn)));
    assert_up_needs_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_q.up && !rise[0]) |=> !out_q.up);
    assert_dn_needs_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_q.dn && !rise[1]) |=> !out_q.dn);
endmodule

// File: tb/pfd_overlap_tb_top.sv
module pfd_overlap_tb_top;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ref_i = 1'b0;
    logic       fb_i = 1'b0;
    logic [3:0] dly_i = 4'd2;
    logic       up_o, dn_o;
    int         n_chk = 0;
    int         n_bad = 0;
    int         c_up, c_dn, c_both;

    always #10ns clk_i = ~clk_i;

    pfd_overlap dut_i (
        .clk_i (clk_i), .rst_ni (rst_ni), .ref_i (ref_i), .fb_i (fb_i),
        .dly_i (dly_i), .up_o (up_o), .dn_o (dn_o)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sample_counts();
        if (up_o) c_up++;
        if (dn_o) c_dn++;
        if (up_o && dn_o) c_both++;
    endtask

    // p > 0: reference leads by p ticks; p < 0: feedback leads by -p ticks
    task automatic run_pair(int p, int d, string req);
        int rs, fs, deff;
        rs = 2 + ((p < 0) ? -p : 0);
        fs = 2 + ((p > 0) ? p : 0);
        deff = (d == 0) ? 1 : d;
        dly_i = 4'(d);
        c_up = 0; c_dn = 0; c_both = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk_i);
            sample_counts();
            ref_i = (k >= rs) && (k < rs + 25);
            fb_i  = (k >= fs) && (k < fs + 25);
        end
        check(req, "up width", c_up, ((p > 0) ? p : 0) + deff);
        check(req, "dn width", c_dn, ((p < 0) ? -p : 0) + deff);
        check(req, "overlap", c_both, deff);
        check(req, "width difference", c_up - c_dn, p);
    endtask

    task automatic run_reset();
        c_up = 0; c_dn = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_i);
            sample_counts();
        end
        check("R1", "up during reset", c_up, 0);
        check("R1", "dn during reset", c_dn, 0);
        rst_ni = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk_i);
            sample_counts();
        end
        check("R1", "up idle after release", c_up, 0);
        check("R1", "dn idle after release", c_dn, 0);
    endtask

    // R7: the reference rises again inside the window and is still high when the clear ends
    task automatic run_ignore();
        dly_i = 4'd8;
        c_up = 0; c_dn = 0; c_both = 0;
        for (int k = 0; k < 44; k++) begin
            @(negedge clk_i);
            sample_counts();
            ref_i = (k >= 2 && k < 4) || (k >= 6 && k < 15) || (k >= 17 && k < 40);
            fb_i  = (k >= 2 && k < 12) || (k >= 14 && k < 40);
        end
        check("R7", "up total", c_up, 16);
        check("R7", "dn total", c_dn, 19);
        check("R7", "overlap total", c_both, 16);
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        run_reset();
        run_pair(0, 3, "R6");
        run_pair(5, 3, "R5_R2");
        run_pair(-7, 4, "R5_R2");
        run_pair(1, 15, "R5");
        run_pair(-20, 2, "R5");
        run_pair(0, 0, "R4");
        run_pair(3, 0, "R4");
        run_pair(0, 1, "R3");
        run_ignore();
        run_pair(-2, 5, "R7_R8");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule